// File: doc/BRIEF.md
# Serial Step-Attenuator Control Port

This block receives a control word for a binary-weighted step attenuator over three wires: a serial clock, a serial data line and a frame-enable line. While the frame-enable line is held low, every rising edge of the serial clock moves one data bit into a shift register, most significant bit first. When the frame-enable line returns high, the shifted word moves into a holding register that drives the attenuator stages. Because of this, the stage settings never pass through a partial value while a word is still arriving.

Six stage-select outputs switch the 32, 16, 8, 4, 2 and 1 dB sections. A 1 inserts a section and a 0 bypasses it. A second output gives the total programmed attenuation in dB. The two most significant bits of the word have no function. The three serial lines are asynchronous to the system clock. They are resynchronised and their edges are detected inside a single clock domain, so each serial level must stay stable for at least SYNC_DEPTH+2 system clock cycles.

Top module: `step_atten_ctrl`

## Requirements
- R1: The control word is 8 bits long and is sent most significant bit first. After a full 8-bit frame and the rising edge of frame enable, the outputs reflect bits 5..0 of that word.
- R2: A data bit is taken at the rising edge of the serial clock. A change on the data line while the serial clock is high has no effect on the bit that was already taken.
- R3: The stage outputs change only as a result of a rising edge on frame enable. While bits are being shifted with frame enable low, the outputs keep their previous value.
- R4: Word bits 7 and 6 have no effect on any output.
- R5: stage_sel[5] drives the 32 dB section, stage_sel[4] 16 dB, stage_sel[3] 8 dB, stage_sel[2] 4 dB, stage_sel[1] 2 dB and stage_sel[0] 1 dB. A 1 inserts the section and a 0 bypasses it.
- R6: atten_db is the sum of the weights of the inserted sections. It therefore equals word bits 5..0 read as an unsigned binary number, and it rises strictly as that number rises.
- R7: Serial clock edges that arrive while frame enable is high change neither the shift register nor the outputs.
- R8: While rst_n is low, the outputs and the shift register are all zeros, so every section is bypassed (0 dB).
- R9: If more than 8 bits are clocked during one frame, the last bits received are the ones kept. If fewer are clocked, the register keeps its previous contents shifted left by the number of bits received, with the new bits in the low positions.
- R10: The serial lines pass through a SYNC_DEPTH-stage synchroniser (default 2). With the default depth, the outputs take their new value on the third system clock edge after frame enable rises, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Frame enable: low while shifting, rising edge loads the outputs |
| stage_sel | output | STAGES | Section insert controls, bit i weighs 2^i dB |
| atten_db | output | STAGES | Total programmed attenuation in dB |

## Verification
The bench sends words whose top two bits are set or clear. A design that leaked bits 7 or 6 into the outputs, or that shifted least significant bit first, would give values swapped or above 63 at those points. It sends frames longer and shorter than 8 bits, clocks the serial line while frame enable is high, and flips the data while the serial clock is high. These catch a design that keeps the first bits instead of the last, one that shifts outside a frame, and one that samples on the wrong edge. Finally, it measures the exact latency from the rise of frame enable and watches the outputs during shifting. A design that updated the outputs as bits arrived, or one that was a cycle early or late, would fail those checks.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
   // Positions of the serial lines inside the synchroniser vector
   localparam int SER_LINES = 3;
   localparam int IDX_DAT   = 0;
   localparam int IDX_CLK   = 1;
   localparam int IDX_EN    = 2;

   // Idle levels applied at reset: enable high, clock and data low
   localparam logic [SER_LINES-1:0] SER_IDLE = 3'b100;

   // Positions inside the edge-detector vector
   localparam int EDGE_LINES = 2;
   localparam int EDG_CLK    = 0;
   localparam int EDG_EN     = 1;
   localparam logic [EDGE_LINES-1:0] EDGE_IDLE = 2'b10;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
   parameter int WIDTH = 3,
   parameter int DEPTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) chain[d] <= RST_VAL;
      end else begin
         chain[0] <= din;
         for (int d = 1; d < DEPTH; d++) chain[d] <= chain[d-1];
      end
   end

   assign dout = chain[DEPTH-1];
endmodule

// File: rtl/sat_edge.sv
module sat_edge #(
   parameter int WIDTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   genvar g;
   generate
      for (g = 0; g < WIDTH; g++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= RST_VAL[g];
            else        prev_q <= lvl[g];
         end
         assign rise[g] = lvl[g] & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/sat_shift.sv
module sat_shift #(
   parameter int KEEP = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            bit_in,
   output logic [KEEP-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (step) q <= {q[KEEP-2:0], bit_in};
   end
endmodule

// File: rtl/sat_hold_dec.sv
module sat_hold_dec #(
   parameter int STAGES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [STAGES-1:0] word,
   output logic [STAGES-1:0] sel,
   output logic [STAGES-1:0] total
);
   logic [STAGES-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= '0;
      else if (load) held_q <= word;
   end

   assign sel = held_q;

   // Weighted sum of inserted sections; section i weighs 2^i dB
   always_comb begin
      total = '0;
      for (int i = 0; i < STAGES; i++) begin
         if (held_q[i]) total = total + (STAGES'(1) << i);
      end
   end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
   import step_atten_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int STAGES     = 6,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_en,
   output logic [STAGES-1:0] stage_sel,
   output logic [STAGES-1:0] atten_db
);
   // Elaboration-time parameter checks
   generate
      if (STAGES < 2 || STAGES > WORD_W) begin : g_bad_stages
         $error("step_atten_ctrl: STAGES must lie in 2..WORD_W");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("step_atten_ctrl: SYNC_DEPTH must be at least 2");
      end
   endgenerate

   logic [SER_LINES-1:0]  raw_lines;
   logic [SER_LINES-1:0]  sync_lines;
   logic [EDGE_LINES-1:0] rises;
   logic                  en_lvl;
   logic                  en_rise;
   logic                  shift_go;
   logic [STAGES-1:0]     shift_q;

   assign raw_lines[IDX_DAT] = ser_dat;
   assign raw_lines[IDX_CLK] = ser_clk;
   assign raw_lines[IDX_EN]  = ser_en;

   sat_sync #(
      .WIDTH  (SER_LINES),
      .DEPTH  (SYNC_DEPTH),
      .RST_VAL(SER_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines),
      .dout (sync_lines)
   );

   sat_edge #(
      .WIDTH  (EDGE_LINES),
      .RST_VAL(EDGE_IDLE)
   ) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({sync_lines[IDX_EN], sync_lines[IDX_CLK]}),
      .rise (rises)
   );

   assign en_lvl   = sync_lines[IDX_EN];
   assign en_rise  = rises[EDG_EN];
   assign shift_go = rises[EDG_CLK] & ~en_lvl;

   // Only the bits that reach a section are stored; higher word bits
   // shift out unobserved, which is identical to keeping and ignoring them.
   sat_shift #(
      .KEEP(STAGES)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (shift_go),
      .bit_in(sync_lines[IDX_DAT]),
      .q     (shift_q)
   );

   sat_hold_dec #(
      .STAGES(STAGES)
   ) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (en_rise),
      .word (shift_q),
      .sel  (stage_sel),
      .total(atten_db)
   );
endmodule

// File: rtl/step_atten_chk.sv
module step_atten_chk #(
   parameter int STAGES = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_lvl,
   input logic              en_rise,
   input logic [STAGES-1:0] shift_q,
   input logic [STAGES-1:0] stage_sel,
   input logic [STAGES-1:0] atten_db
);
   // R3: outputs hold unless enable rose
   a_r3_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
      !en_rise |=> $stable(stage_sel));

   // R7: no shifting while enable is high
   a_r7_shift_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      en_lvl |=> $stable(shift_q));

   // R6: a larger stage selection gives a larger attenuation
   a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stage_sel) < stage_sel) |-> ($past(atten_db) < atten_db));

   // R8: reset clears everything
   a_r8_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (stage_sel == '0 && atten_db == '0 && shift_q == '0));
endmodule

bind step_atten_ctrl step_atten_chk #(.STAGES(STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_lvl   (en_lvl),
   .en_rise  (en_rise),
   .shift_q  (shift_q),
   .stage_sel(stage_sel),
   .atten_db (atten_db)
);

// File: tb/test_step_atten_ctrl.sv
`timescale 1ns/1ps
module test_step_atten_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       s_clk, s_dat, s_en;
   logic [5:0] stage_sel, atten_db;
   int         checks = 0;
   int         failures = 0;

   always #5 clk = ~clk;

   step_atten_ctrl i_step_atten_ctrl (
      .clk(clk), .rst_n(rst_n), .ser_clk(s_clk), .ser_dat(s_dat),
      .ser_en(s_en), .stage_sel(stage_sel), .atten_db(atten_db)
   );

   // {word, expected dB}
   localparam logic [13:0] VEC [10] = '{
      {8'h00, 6'd0},  {8'h3F, 6'd63}, {8'hFF, 6'd63}, {8'hC0, 6'd0},
      {8'h2A, 6'd42}, {8'h15, 6'd21}, {8'h01, 6'd1},  {8'h20, 6'd32},
      {8'h85, 6'd5},  {8'h7E, 6'd62}
   };

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [15:0] bits, input int n, input bit late_flip);
      for (int i = n - 1; i >= 0; i--) begin
         s_dat = bits[i];
         s_clk = 1'b0;
         wait_n(4);
         s_clk = 1'b1;
         if (late_flip) begin
            wait_n(2);
            s_dat = ~bits[i];
            wait_n(2);
         end else begin
            wait_n(4);
         end
      end
      s_clk = 1'b0;
      wait_n(4);
   endtask

   task automatic open_frame();
      s_en = 1'b0;
      wait_n(4);
   endtask

   task automatic close_frame();
      s_en = 1'b1;
      wait_n(6);
   endtask

   task automatic load_word(input logic [7:0] w);
      open_frame();
      shift_bits({8'h00, w}, 8, 1'b0);
      close_frame();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [5:0] prev;
      rst_n = 1'b0; s_clk = 1'b0; s_dat = 1'b0; s_en = 1'b1;
      wait_n(3);
      chk("R8 reset sel", stage_sel, 6'd0);
      chk("R8 reset dB", atten_db, 6'd0);
      rst_n = 1'b1;
      wait_n(3);

      // Vector table: R1 order, R4 ignored top bits, R5 section map
      for (int v = 0; v < 10; v++) begin
         load_word(VEC[v][13:6]);
         chk("R1/R4/R5 stage_sel", stage_sel, VEC[v][5:0]);
         chk("R1/R4/R6 atten_db", atten_db, VEC[v][5:0]);
      end

      // R6: sweep all settings, strictly rising
      prev = 6'd0;
      for (int s = 0; s < 64; s++) begin
         load_word({2'b10, 6'(s)});
         chk("R6 sweep value", atten_db, 6'(s));
         if (s > 0) begin
            checks++;
            if (!(atten_db > prev)) begin
               failures++;
               $display("FAIL R6 not rising actual=%0d expected>%0d", atten_db, prev);
            end
         end
         prev = atten_db;
      end

      // R2: data flips while serial clock is high
      open_frame();
      shift_bits(16'h0015, 8, 1'b1);
      close_frame();
      chk("R2 capture on rising edge", atten_db, 6'd21);

      // R9: long frame keeps the last bits
      open_frame();
      shift_bits(16'h0ABC, 12, 1'b0);
      close_frame();
      chk("R9 long frame", atten_db, 6'd60);

      // R9: short frame shifts previous contents
      load_word(8'h05);
      open_frame();
      shift_bits(16'h0005, 3, 1'b0);
      close_frame();
      chk("R9 short frame", atten_db, 6'd45);

      // R7: clocks while enable is high are ignored
      shift_bits(16'h00FF, 8, 1'b0);
      chk("R7 outputs untouched", atten_db, 6'd45);
      open_frame();
      close_frame();
      chk("R7 shift register untouched", atten_db, 6'd45);

      // R3 and R10: no change during shifting, exact load latency
      open_frame();
      shift_bits(16'h0012, 8, 1'b0);
      chk("R3 held while shifting", stage_sel, 6'd45);
      s_en = 1'b1;
      wait_n(2);
      chk("R10 not yet loaded", stage_sel, 6'd45);
      wait_n(1);
      chk("R10 loaded on third edge", stage_sel, 6'd18);
      wait_n(4);

      // R8: reset in mid-run clears outputs and shift register
      load_word(8'h3F);
      rst_n = 1'b0;
      wait_n(2);
      chk("R8 async clear", atten_db, 6'd0);
      rst_n = 1'b1;
      wait_n(2);
      open_frame();
      close_frame();
      chk("R8 shift register cleared", atten_db, 6'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule